// File: doc/BRIEF.md
# Dual-Drive Phase/Frequency Comparator

This block decides, once per reference period, whether the divided local-oscillator pulse is running ahead of or behind the reference pulse. It turns that decision into a correction pulse on two tri-state charge-pump control pins. Each pin is presented as a drive level plus an output-enable, and a low enable means high impedance. While the divider edge leads, a pin drives High. While the reference edge leads, it drives Low. When neither is pending, both pins float.

The primary pin always carries the correction pulse. The auxiliary pin normally mirrors it, so that two loop filters with different constants can share one comparator. Software can park the auxiliary pin at high impedance, or use it as a plain output port that shows a register bit. In fast-lock mode, which only takes effect while the fast system clock is selected, the auxiliary pin joins a pulse only after the error has lasted a fixed number of clocks (`THRESH_CYC`, default 5). Small errors are therefore corrected by the primary pin alone, and large errors by both pins.

Top module: `pfd_dual_drive`

## Requirements
- R1: While the synchronous active-low reset is asserted, both pins are at high impedance on the next clock (aux mode 2'b00).
- R2: A divider rising edge sampled while no pulse is pending, and with no reference edge in the same cycle, makes the primary pin drive High from the next cycle.
- R3: A reference rising edge sampled while no pulse is pending, and with no divider edge in the same cycle, makes the primary pin drive Low from the next cycle.
- R4: Divider and reference rising edges sampled in the same cycle count as a match and produce no pulse.
- R5: A pulse ends on the cycle after the lagging edge is sampled, so the primary pin is enabled for exactly as many cycles as the edges are apart.
- R6: Further leading-input edges while a pulse is pending neither end nor restart that pulse.
- R7: With aux mode 2'b00 (follow) and fast lock inactive, the auxiliary pin matches the primary pin in enable and level on every cycle.
- R8: With aux mode 2'b00 and fast lock active, the auxiliary pin stays at high impedance for the first `THRESH_CYC` cycles of a pulse. For the rest of that pulse it matches the primary pin, so a pulse of N cycles yields max(0, N-`THRESH_CYC`) auxiliary cycles.
- R9: A fast-lock request has no effect while the fast clock is not selected, and the auxiliary pin then behaves as in R7.
- R10: Aux mode 2'b01 or 2'b11 keeps the auxiliary pin at high impedance, and the primary pin is unaffected.
- R11: Aux mode 2'b10 drives the auxiliary pin continuously with the port value, whatever the pulses are doing.
- R12: Asserting reset in the middle of a pulse returns the primary pin to high impedance on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; fast-lock threshold is counted in its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| div_pulse | input | 1 | Divided local-oscillator pulse, synchronous to clk |
| ref_pulse | input | 1 | Reference pulse, synchronous to clk |
| hs_lock_req | input | 1 | Fast-lock request |
| fast_clk_sel | input | 1 | High when the fast system clock is in use |
| aux_mode | input | 2 | 00 follow, 01/11 float, 10 port |
| aux_port_val | input | 1 | Level for the auxiliary pin in port mode |
| do1_drv | output | 1 | Primary pin drive level |
| do1_oe | output | 1 | Primary pin enable (0 = high impedance) |
| do2_drv | output | 1 | Auxiliary pin drive level |
| do2_oe | output | 1 | Auxiliary pin enable (0 = high impedance) |

## Verification
The assertions take for granted that both pulse inputs are already synchronous to `clk` and are held low while reset is asserted. Under that assumption, a rising edge seen by the design is the same one a clocked `$rose` sees. The bench drives every input on the falling clock edge and holds both pulses low through reset and through a short idle gap before each case. As a result, every case starts with no pulse pending, and pulses are separated by at least one idle cycle.

// File: rtl/pfd_pkg.sv
// Package: shared types for the dual-drive phase comparator.
// Assumes nothing; holds the auxiliary-pin mode encoding and pin pair type.
package pfd_pkg;

    // Auxiliary pin operating mode, as presented on aux_mode
    typedef enum logic [1:0] {
        AUX_FOLLOW    = 2'b00,
        AUX_FLOAT     = 2'b01,
        AUX_PORT      = 2'b10,
        AUX_FLOAT_ALT = 2'b11
    } aux_mode_e;

    // One tri-state pin: level and enable (oe low = high impedance)
    typedef struct packed {
        logic drv;
        logic oe;
    } pin_t;

endpackage

// File: rtl/pfd_edge_det.sv
// Module: pfd_edge_det
// Detects rising edges on a vector of clk-synchronous inputs.
// Assumes inputs are already synchronous. The history register is not reset:
// it tracks the previous sampled value at all times, so an edge is judged
// exactly as a clocked $rose would judge it.
module pfd_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Remember last sampled level of this input
        always_ff @(posedge clk) begin
            prev_q[g] <= sig[g];
        end
        assign rise[g] = sig[g] & ~prev_q[g];
    end

endmodule

// File: rtl/pfd_flag_core.sv
// Module: pfd_flag_core
// Holds the up (divider leads) and down (reference leads) flags.
// The leading edge sets its flag; the lagging edge clears both flags.
// Simultaneous edges count as a match and clear everything.
// Assumes the rise strobes last one cycle each.
module pfd_flag_core (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_div,
    input  logic rise_ref,
    output logic up_q,
    output logic dn_q
);

    // Phase decision: set on leading edge, clear on lagging edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            unique case ({rise_div, rise_ref})
                2'b10: begin
                    if (dn_q) begin
                        dn_q <= 1'b0;
                    end else begin
                        up_q <= 1'b1;
                    end
                end
                2'b01: begin
                    if (up_q) begin
                        up_q <= 1'b0;
                    end else begin
                        dn_q <= 1'b1;
                    end
                end
                2'b11: begin
                    up_q <= 1'b0;
                    dn_q <= 1'b0;
                end
                default: begin
                    up_q <= up_q;
                    dn_q <= dn_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfd_err_timer.sv
// Module: pfd_err_timer
// Counts the cycles a correction pulse has lasted, saturating at THRESH.
// 'over' goes high once THRESH full cycles of the pulse have passed.
// Assumes pulses are separated by at least one idle cycle.
module pfd_err_timer #(
    parameter int THRESH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic over
);

    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    logic [CNT_W-1:0] cnt_q;

    // Age of the current pulse, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over = (cnt_q == LIMIT);

endmodule

// File: rtl/pfd_pin_drive.sv
// Module: pfd_pin_drive
// Turns the up/down flags into a tri-state pin pair.
// 'allow' low keeps the pin floating even while a pulse is pending.
// Assumes up and dn are never both set.
module pfd_pin_drive
    import pfd_pkg::*;
(
    input  logic up,
    input  logic dn,
    input  logic allow,
    output pin_t pin
);

    // Drive High for up, Low for down, float otherwise
    always_comb begin
        pin.oe  = (up | dn) & allow;
        pin.drv = up;
    end

endmodule

// File: rtl/pfd_dual_drive.sv
// Module: pfd_dual_drive (top)
// Phase/frequency comparator with a primary and an auxiliary tri-state
// charge-pump output. The auxiliary pin follows the primary, is gated by the
// fast-lock threshold, floats, or acts as a port, depending on aux_mode.
// Assumes div_pulse and ref_pulse are synchronous to clk.
module pfd_dual_drive
    import pfd_pkg::*;
#(
    parameter int THRESH_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_pulse,
    input  logic       ref_pulse,
    input  logic       hs_lock_req,
    input  logic       fast_clk_sel,
    input  logic [1:0] aux_mode,
    input  logic       aux_port_val,
    output logic       do1_drv,
    output logic       do1_oe,
    output logic       do2_drv,
    output logic       do2_oe
);

    localparam int NPIN = 2;

    logic [1:0]      rise;
    logic            up_q;
    logic            dn_q;
    logic            over;
    logic            fast_on;
    logic [NPIN-1:0] allow;
    pin_t            pin_raw [NPIN];
    aux_mode_e       mode;

    pfd_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .sig  ({ref_pulse, div_pulse}),
        .rise (rise)
    );

    pfd_flag_core u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_div (rise[0]),
        .rise_ref (rise[1]),
        .up_q     (up_q),
        .dn_q     (dn_q)
    );

    pfd_err_timer #(.THRESH(THRESH_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (up_q | dn_q),
        .over   (over)
    );

    // Fast lock only counts while the fast clock drives the block
    assign fast_on  = hs_lock_req & fast_clk_sel;
    assign allow[0] = 1'b1;
    assign allow[1] = ~fast_on | over;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pfd_pin_drive u_drv (
            .up    (up_q),
            .dn    (dn_q),
            .allow (allow[p]),
            .pin   (pin_raw[p])
        );
    end

    assign mode    = aux_mode_e'(aux_mode);
    assign do1_drv = pin_raw[0].drv;
    assign do1_oe  = pin_raw[0].oe;

    // Auxiliary pin source selection
    always_comb begin
        unique case (mode)
            AUX_FOLLOW: begin
                do2_drv = pin_raw[1].drv;
                do2_oe  = pin_raw[1].oe;
            end
            AUX_PORT: begin
                do2_drv = aux_port_val;
                do2_oe  = 1'b1;
            end
            default: begin
                do2_drv = 1'b0;
                do2_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pfd_dual_drive_chk.sv
// Module: pfd_dual_drive_chk
// Property checker bound to pfd_dual_drive. Observes ports only.
// Assumes pulse inputs are low while reset is asserted.
module pfd_dual_drive_chk #(
    parameter int THRESH_CYC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       div_pulse,
    input logic       ref_pulse,
    input logic       hs_lock_req,
    input logic       fast_clk_sel,
    input logic [1:0] aux_mode,
    input logic       aux_port_val,
    input logic       do1_drv,
    input logic       do1_oe,
    input logic       do2_drv,
    input logic       do2_oe
);

    localparam int RW = $clog2(THRESH_CYC + 1);
    localparam logic [RW-1:0] RLIM = RW'(THRESH_CYC);

    logic [RW-1:0] run_q;
    logic          fast_c;
    logic          follow_c;

    assign fast_c   = hs_lock_req & fast_clk_sel;
    assign follow_c = (aux_mode == 2'b00);

    // Length of the current primary-pin pulse, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!do1_oe) begin
            run_q <= '0;
        end else if (run_q != RLIM) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_reset_float_R12: assert property (@(posedge clk)
        !rst_n |=> !do1_oe);

    assert_div_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!do1_oe && $rose(div_pulse) && !$rose(ref_pulse)) |=> (do1_oe && do1_drv));

    assert_ref_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!do1_oe && $rose(ref_pulse) && !$rose(div_pulse)) |=> (do1_oe && !do1_drv));

    assert_match_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!do1_oe && $rose(ref_pulse) && $rose(div_pulse)) |=> !do1_oe);

    assert_lag_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do1_oe && do1_drv && $rose(ref_pulse)) |=> !do1_oe);

    assert_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do1_oe && do1_drv && !$rose(ref_pulse)) |=> (do1_oe && do1_drv));

    // R7 and R9: no fast lock in effect, auxiliary mirrors primary
    assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (follow_c && !fast_c) |-> (do2_oe == do1_oe && (!do1_oe || do2_drv == do1_drv)));

    assert_fast_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (follow_c && fast_c && run_q < RLIM) |-> !do2_oe);

    assert_fast_join_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (follow_c && fast_c && do1_oe && run_q == RLIM) |-> (do2_oe && do2_drv == do1_drv));

    assert_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_mode[0]) |-> !do2_oe);

    assert_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_mode == 2'b10) |-> (do2_oe && do2_drv == aux_port_val));

endmodule

bind pfd_dual_drive pfd_dual_drive_chk #(.THRESH_CYC(THRESH_CYC)) u_chk (.*);

// File: tb/pfd_dual_drive_tb.sv
// Bench: sweeps edge separation, leading input, fast-lock settings and
// auxiliary modes; expected pulse counts are computed arithmetically.
module pfd_dual_drive_tb;

    localparam int TH = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_pulse = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       hs_lock_req = 1'b0;
    logic       fast_clk_sel = 1'b0;
    logic [1:0] aux_mode = 2'b00;
    logic       aux_port_val = 1'b0;
    logic       do1_drv;
    logic       do1_oe;
    logic       do2_drv;
    logic       do2_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pfd_dual_drive #(.THRESH_CYC(TH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_pulse    (div_pulse),
        .ref_pulse    (ref_pulse),
        .hs_lock_req  (hs_lock_req),
        .fast_clk_sel (fast_clk_sel),
        .aux_mode     (aux_mode),
        .aux_port_val (aux_port_val),
        .do1_drv      (do1_drv),
        .do1_oe       (do1_oe),
        .do2_drv      (do2_drv),
        .do2_oe       (do2_oe)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Record one check and report a mismatch
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One scenario: leading input rises, lagging one follows d cycles later
    task automatic run_case(input bit lead_div, input int d, input bit fen,
                            input bit fclk, input logic [1:0] mode, input bit pv);
        int n1 = 0;
        int n2 = 0;
        int badpol = 0;
        int mism = 0;
        int portbad = 0;
        int exp2;
        string r1;
        string r2;
        @(negedge clk);
        hs_lock_req  = fen;
        fast_clk_sel = fclk;
        aux_mode     = mode;
        aux_port_val = pv;
        div_pulse    = 1'b0;
        ref_pulse    = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i <= d + 8; i++) begin
            @(negedge clk);
            if (do1_oe) begin
                n1++;
                if (do1_drv != lead_div) badpol++;
            end
            if (do2_oe) n2++;
            if (mode == 2'b00 && do1_oe && do2_oe && do2_drv != do1_drv) mism++;
            if (mode == 2'b10 && (!do2_oe || do2_drv != pv)) portbad++;
            if (lead_div) begin
                div_pulse = (i <= d + 2);
                ref_pulse = (i >= d && i <= d + 2);
            end else begin
                ref_pulse = (i <= d + 2);
                div_pulse = (i >= d && i <= d + 2);
            end
        end
        r1 = (d == 0) ? "R4 match" : "R5 width";
        check(n1 == d, r1, n1, d);
        r1 = lead_div ? "R2 polarity" : "R3 polarity";
        check(badpol == 0, r1, badpol, 0);
        if (mode == 2'b10) begin
            check(portbad == 0, "R11 port", portbad, 0);
        end else if (mode[0]) begin
            check(n2 == 0, "R10 float", n2, 0);
        end else begin
            if (fen && fclk) begin
                exp2 = (d > TH) ? d - TH : 0;
                r2 = "R8 fast";
            end else begin
                exp2 = d;
                r2 = fen ? "R9 no fast clock" : "R7 follow";
            end
            check(n2 == exp2, r2, n2, exp2);
            check(mism == 0, r2, mism, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!do1_oe, "R1 do1 float", do1_oe, 0);
        check(!do2_oe, "R1 do2 float", do2_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Main sweep
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                for (int ld = 0; ld < 2; ld++) begin
                    for (int d = 0; d <= 9; d++) begin
                        run_case(ld[0], d, f[0], f[1], m[1:0], d[0]);
                    end
                end
            end
        end

        // R6: extra divider edges while pending do not restart the pulse
        begin
            int n = 0;
            aux_mode = 2'b00;
            hs_lock_req = 1'b0;
            repeat (3) @(negedge clk);
            for (int i = 0; i <= 14; i++) begin
                @(negedge clk);
                if (do1_oe && do1_drv) n++;
                div_pulse = (i <= 1) || (i >= 4 && i <= 9);
                ref_pulse = (i >= 7 && i <= 9);
            end
            check(n == 7, "R6 retrigger", n, 7);
        end

        // R12: reset in mid-pulse
        repeat (3) @(negedge clk);
        ref_pulse = 1'b1;
        repeat (3) @(negedge clk);
        check(do1_oe && !do1_drv, "R12 pulse active", do1_oe, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!do1_oe, "R12 reset float", do1_oe, 0);
        ref_pulse = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!do1_oe && !do2_oe, "R12 idle after reset", do1_oe, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule